// File: doc/BRIEF.md
# Floating-Point Immediate Constructor

This block forms the value that goes into a double-precision floating-point register from 16-bit constants. It offers two operations. A load takes the immediate as the top half of a single-precision bit pattern, fills the lower half with zeros, widens the pattern to double precision and writes it out. An insert takes the register's current contents, narrows them to a single-precision bit pattern, puts the immediate in the low 16 bits, widens the patched value and writes it back.

A load followed by an insert builds any single-precision constant in two steps. A load alone gives any bfloat16 constant, which includes zero, ±1.0, the infinities and a quiet NaN. The block never raises a floating-point flag. The register file, instruction decode and all status state are outside this block. The caller presents an operation with its immediate and the current register value. One clock later the block returns a 64-bit result and a write strobe.

Top module: `fpimm_ctor`

## Requirements
- R1: A load (op_sel = 0) produces the double-precision widening of the single pattern {imm, 16'h0000}, and reg_cur has no effect on it. For example, imm 0x0000 gives 0x0000_0000_0000_0000 and imm 0x3FFF gives 0x3FFF_E000_0000_0000.
- R2: The ordinary constants load as follows: 0x3F80 gives 0x3FF0_0000_0000_0000, 0xBF80 gives 0xBFF0_0000_0000_0000, 0x8000 gives 0x8000_0000_0000_0000 and 0xBFC0 gives 0xBFF8_0000_0000_0000.
- R3: A single exponent of all ones becomes a double exponent of 0x7FF, and the mantissa payload is kept in the top mantissa bits. For example, 0x7F80 loads as 0x7FF0_0000_0000_0000, 0xFF80 as 0xFFF0_0000_0000_0000 and 0x7FC0 as 0x7FF8_0000_0000_0000. Inserting 0x0001 into 0x7FF0_0000_0000_0000 gives 0x7FF0_0000_2000_0000.
- R4: An insert (op_sel = 1) narrows reg_cur to 32 bits, replaces bits 15:0 of that pattern with imm, and widens the result. Loading 0x3F80 and then inserting 0x8000 gives 0x3FF0_1000_0000_0000.
- R5: Narrowing copies bits without rounding. The single sign is bit 63. The single exponent is {bit 62, bits 58:52}. The single mantissa is bits 51:29. Bits 61:59 and 28:0 of reg_cur are dropped, so bits 28:0 of every result are zero.
- R6: Single subnormals are normalised into double normals. Load 0x0040 gives 0x3800_0000_0000_0000 and load 0x0001 gives 0x37A0_0000_0000_0000. Inserting 0x0003 into zero gives 0x36B8_0000_0000_0000.
- R7: The result and wr_en are registered. wr_en is 1 in exactly the cycle after op_valid was 1, and 0 otherwise. Operations may be issued back to back. The result holds its value when no operation is presented.
- R8: While rst_n is low, result is 0 and wr_en is 0.
- R9: An insert keeps the sign and the upper 16 bits of the narrowed pattern. Inserting 0x1234 into 0xC000_0000_0000_0000 gives 0xC000_0246_8000_0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 1 | 0 = load upper half, 1 = insert lower half |
| imm | input | 16 | Immediate operand |
| reg_cur | input | 64 | Current destination register contents |
| result | output | 64 | Value to write to the destination |
| wr_en | output | 1 | Write strobe for result |

## Verification
The bench targets the places where the widening and narrowing most easily go wrong:
- **Single subnormals.** A design that only rebiased the exponent would return tiny denormal-looking doubles.
- **All-ones exponents.** A design that added the bias difference to them would turn infinities and NaNs into large finite numbers.
- **Out-of-range double exponents.** The narrowing must pick the exponent bits, not clamp or round. A narrowing that rounded, or that looked at exponent bits 61:59, would give a different value from a register whose exponent lies outside single range, or from one whose low mantissa bits are set.
- **The insert chain, sign and idle cycles.** The two-step load/insert chain and a negative register show whether the insert keeps the sign and upper half. Idle cycles show whether the strobe or the result leaks past an operation.

// File: rtl/fpimm_pkg.sv
package fpimm_pkg;
    localparam int IMM_W  = 16;
    localparam int SP_EXP = 8;
    localparam int SP_MAN = 23;
    localparam int DP_EXP = 11;
    localparam int DP_MAN = 52;
    localparam int SP_W   = 1 + SP_EXP + SP_MAN;
    localparam int DP_W   = 1 + DP_EXP + DP_MAN;

    typedef enum logic {
        OP_LOAD   = 1'b0,
        OP_INSERT = 1'b1
    } fpimm_op_e;

    typedef struct packed {
        logic [DP_W-1:0] result;
        logic            wr;
    } fpimm_state_t;
endpackage

// File: rtl/fpimm_narrow.sv
module fpimm_narrow #(
    parameter int SE = fpimm_pkg::SP_EXP,
    parameter int SM = fpimm_pkg::SP_MAN,
    parameter int DE = fpimm_pkg::DP_EXP,
    parameter int DM = fpimm_pkg::DP_MAN
) (
    input  logic [DE+DM:0] dbl_in,
    output logic [SE+SM:0] sgl_out
);
    localparam int LOW_EXP = SE - 1;

    always_comb begin
        sgl_out = {dbl_in[DE+DM],
                   dbl_in[DE+DM-1],
                   dbl_in[DM+LOW_EXP-1 -: LOW_EXP],
                   dbl_in[DM-1 -: SM]};
    end
endmodule

// File: rtl/fpimm_widen.sv
module fpimm_widen #(
    parameter int SE = fpimm_pkg::SP_EXP,
    parameter int SM = fpimm_pkg::SP_MAN,
    parameter int DE = fpimm_pkg::DP_EXP,
    parameter int DM = fpimm_pkg::DP_MAN
) (
    input  logic [SE+SM:0] sgl_in,
    output logic [DE+DM:0] dbl_out
);
    localparam int SBIAS    = (1 << (SE - 1)) - 1;
    localparam int DBIAS    = (1 << (DE - 1)) - 1;
    localparam int BIAS_D   = DBIAS - SBIAS;
    localparam int SUB_OFF  = DBIAS - SBIAS - SM + 1;
    localparam int PAD      = DM - SM;

    logic          s_sign;
    logic [SE-1:0] s_exp;
    logic [SM-1:0] s_man;
    logic [DE-1:0] d_exp;
    logic [SM-1:0] d_man_top;
    logic [SM-1:0] shifted;
    int            lead;

    assign s_sign = sgl_in[SE+SM];
    assign s_exp  = sgl_in[SE+SM-1:SM];
    assign s_man  = sgl_in[SM-1:0];

    always_comb begin
        lead = 0;
        for (int i = 0; i < SM; i++) begin
            if (s_man[i]) lead = i;
        end
        shifted = s_man << (SM - lead);
        if (s_exp == '0) begin
            if (s_man == '0) begin
                d_exp     = '0;
                d_man_top = '0;
            end else begin
                d_exp     = DE'(lead + SUB_OFF);
                d_man_top = shifted;
            end
        end else if (s_exp == '1) begin
            d_exp     = '1;
            d_man_top = s_man;
        end else begin
            d_exp     = DE'(int'(s_exp) + BIAS_D);
            d_man_top = s_man;
        end
        dbl_out = {s_sign, d_exp, d_man_top, {PAD{1'b0}}};
    end
endmodule

// File: rtl/fpimm_ctor.sv
module fpimm_ctor
    import fpimm_pkg::*;
#(
    parameter int IW = fpimm_pkg::IMM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic             op_sel,
    input  logic [IW-1:0]    imm,
    input  logic [DP_W-1:0]  reg_cur,
    output logic [DP_W-1:0]  result,
    output logic             wr_en
);
    localparam int HI_W = SP_W - IW;

    fpimm_state_t state_d, state_q;
    fpimm_op_e    op;
    logic [SP_W-1:0] narrowed;
    logic [SP_W-1:0] sgl_pat;
    logic [DP_W-1:0] widened;

    assign op = fpimm_op_e'(op_sel);

    fpimm_narrow u_narrow (
        .dbl_in  (reg_cur),
        .sgl_out (narrowed)
    );

    always_comb begin
        if (op == OP_INSERT) sgl_pat = {narrowed[SP_W-1 -: HI_W], imm};
        else                 sgl_pat = {imm, {HI_W{1'b0}}};
    end

    fpimm_widen u_widen (
        .sgl_in  (sgl_pat),
        .dbl_out (widened)
    );

    always_comb begin
        state_d        = state_q;
        state_d.wr     = op_valid;
        if (op_valid) state_d.result = widened;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign result = state_q.result;
    assign wr_en  = state_q.wr;

    p_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> wr_en);
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!wr_en && $stable(result)));
    p_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (result[28:0] == '0));
    p_load_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_sel) |=> (result[DP_W-1] == $past(imm[IW-1])));
    p_ins_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel) |=> (result[DP_W-1] == $past(reg_cur[DP_W-1])));
    p_special_exp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_sel && imm[IW-2 -: SP_EXP] == '1)
            |=> (result[DP_W-2 -: DP_EXP] == '1));
endmodule

// File: tb/tb_fpimm_ctor.sv
module tb_fpimm_ctor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_sel = 1'b0;
    logic [15:0] imm = '0;
    logic [63:0] reg_cur = '0;
    logic [63:0] result;
    logic        wr_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fpimm_ctor dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .imm(imm), .reg_cur(reg_cur), .result(result), .wr_en(wr_en)
    );

    localparam int NV = 18;
    // {op, imm, reg, expected}
    localparam logic [144:0] VEC [NV] = '{
        {1'b0, 16'h3F80, 64'h0, 64'h3FF0_0000_0000_0000},                    // R2
        {1'b0, 16'hBF80, 64'h0, 64'hBFF0_0000_0000_0000},                    // R2
        {1'b0, 16'h8000, 64'h0, 64'h8000_0000_0000_0000},                    // R2
        {1'b0, 16'hBFC0, 64'h0, 64'hBFF8_0000_0000_0000},                    // R2
        {1'b0, 16'h0000, 64'h0, 64'h0},                                      // R1
        {1'b0, 16'h3FFF, 64'h0, 64'h3FFF_E000_0000_0000},                    // R1
        {1'b0, 16'h3F80, 64'hFFFF_FFFF_FFFF_FFFF, 64'h3FF0_0000_0000_0000},  // R1 reg ignored
        {1'b0, 16'h7F80, 64'h0, 64'h7FF0_0000_0000_0000},                    // R3
        {1'b0, 16'hFF80, 64'h0, 64'hFFF0_0000_0000_0000},                    // R3
        {1'b0, 16'h7FC0, 64'h0, 64'h7FF8_0000_0000_0000},                    // R3
        {1'b1, 16'h0001, 64'h7FF0_0000_0000_0000, 64'h7FF0_0000_2000_0000},  // R3
        {1'b0, 16'h0040, 64'h0, 64'h3800_0000_0000_0000},                    // R6
        {1'b0, 16'h0001, 64'h0, 64'h37A0_0000_0000_0000},                    // R6
        {1'b1, 16'h0003, 64'h0, 64'h36B8_0000_0000_0000},                    // R6
        {1'b1, 16'h8000, 64'h3FF0_0000_0000_0000, 64'h3FF0_1000_0000_0000},  // R4
        {1'b1, 16'h1234, 64'hC000_0000_0000_0000, 64'hC000_0246_8000_0000},  // R9
        {1'b1, 16'h0000, 64'h3FF0_0000_1FFF_FFFF, 64'h3FF0_0000_0000_0000},  // R5
        {1'b1, 16'h0000, 64'h4FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000}   // R5
    };

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic sel, input logic [15:0] im, input logic [63:0] rv);
        @(negedge clk);
        op_valid = 1'b1; op_sel = sel; imm = im; reg_cur = rv;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        chk("R8 reset result", result, 64'h0);
        chk("R8 reset wr_en", {63'h0, wr_en}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][144], VEC[i][143:128], VEC[i][127:64]);
            chk($sformatf("vector %0d result", i), result, VEC[i][63:0]);
            chk($sformatf("R7 vector %0d wr_en", i), {63'h0, wr_en}, 64'h1);
        end

        // R7: idle cycle drops strobe, result held
        held = result;
        @(negedge clk);
        chk("R7 idle wr_en", {63'h0, wr_en}, 64'h0);
        chk("R7 idle hold", result, held);

        // R4: two-step chain fed back through the register input
        issue(1'b0, 16'h3F80, 64'h0);
        held = result;
        issue(1'b1, 16'h8000, held);
        chk("R4 chain", result, 64'h3FF0_1000_0000_0000);

        // R7: back-to-back operations
        @(negedge clk);
        op_valid = 1'b1; op_sel = 1'b0; imm = 16'hBF80; reg_cur = '0;
        @(negedge clk);
        chk("R7 b2b first", result, 64'hBFF0_0000_0000_0000);
        chk("R7 b2b first wr_en", {63'h0, wr_en}, 64'h1);
        op_sel = 1'b1; imm = 16'h8000; reg_cur = 64'h3FF0_0000_0000_0000;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R7 b2b second", result, 64'h3FF0_1000_0000_0000);
        chk("R7 b2b second wr_en", {63'h0, wr_en}, 64'h1);

        // R8: reset mid-run clears state
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 re-reset result", result, 64'h0);
        chk("R8 re-reset wr_en", {63'h0, wr_en}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule